// File: doc/BRIEF.md
# Leaky Integrate-and-Fire Neuron Cell

This cell keeps the membrane potential of one spiking neuron. Partial sums arrive from an in-memory multiply array one row per clock, and the cell adds each one to its potential while the compute enable is high. The accumulation window for one time step therefore lasts as many cycles as the input depth. A strobe closes the window. On that edge the cell subtracts a leak that depends on the state. The leak is a signed offset plus the potential shifted arithmetically right by a programmable amount. On the following edge the cell compares the leaked potential with a programmable threshold. If the potential is strictly above the threshold, the cell emits a one-cycle spike and clears the potential. Otherwise the potential carries into the next time step.

The potential is also driven out so that a downstream maximum tracker can read it. In learning mode two extra rules apply. A cell that fires freezes until the weight write-back is reported done. A cell that the controller has not selected performs no potential calculation at all.

Top module: `lif_neuron_cell`

## Requirements
- R1: After reset, `vmem` is 0 and `spike` is 0.
- R2: In an accumulation cycle (not holding, not gated, not the check cycle, `window_done` low), `psum_valid` high makes the next `vmem` equal to `vmem + psum`, saturated to the signed 16-bit range [-32768, 32767]. When `psum_valid` is low, `vmem` is unchanged.
- R3: When `window_done` is high in an accumulation cycle, the next `vmem` is `vmem - (leak_offset + (vmem >>> leak_shift))`, saturated to 16 bits. Any `psum` presented in that cycle is discarded.
- R4: In the cycle after the leak step (the check cycle), a leaked `vmem` strictly greater than `threshold` (signed) sets `spike` and clears `vmem` on the next edge. Otherwise `vmem` is kept. In the check cycle, `psum_valid` and `window_done` are ignored.
- R5: `spike` is high for exactly one cycle per firing.
- R6: If the cell fires with `learn_mode` high, `vmem` stays 0 and `psum_valid` and `window_done` are ignored until a cycle with `wb_done` high. Accumulation resumes in the cycle after that one. With `learn_mode` low, firing causes no hold.
- R7: While `learn_mode` is high and `filter_sel` is low, `psum_valid` and `window_done` have no effect and `vmem` is stable. While `learn_mode` is low, `filter_sel` has no effect.
- R8: Saturation holds for the leak subtraction in both directions: a result above 32767 gives 32767, and a result below -32768 gives -32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psum_valid | input | 1 | Compute enable for `psum` |
| psum | input | 16 | Signed partial sum from the array |
| window_done | input | 1 | Ends the accumulation window; triggers the leak |
| threshold | input | 16 | Signed firing threshold |
| leak_offset | input | 16 | Signed constant part of the leak |
| leak_shift | input | 4 | Right-shift amount for the proportional part of the leak |
| learn_mode | input | 1 | Learning mode |
| filter_sel | input | 1 | Filter selected for potential calculation (learning mode only) |
| wb_done | input | 1 | Weight write-back completed; releases the hold |
| spike | output | 1 | One-cycle output spike |
| vmem | output | 16 | Signed membrane potential |

## Verification
Each result is due a fixed number of cycles after its stimulus:
- An accumulated partial sum shows on `vmem` one edge after it is driven.
- The leaked value shows one edge after `window_done`.
- The spike and the cleared potential show two edges after `window_done`, and `spike` falls on the edge after that.
- The release from hold takes effect one edge after `wb_done`, so a partial sum is accepted starting the cycle after the strobe.

The bench drives inputs just after a falling edge and compares outputs at the next falling edge, one register stage later. During the check and hold cycles it presents conflicting inputs, so that a cell ignoring them is told apart from one that acts on them.

// File: rtl/lif_neuron_cell.sv
module lif_neuron_cell #(
  parameter int W   = 16,
  parameter int SHW = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                psum_valid,
  input  logic signed [W-1:0] psum,
  input  logic                window_done,
  input  logic signed [W-1:0] threshold,
  input  logic signed [W-1:0] leak_offset,
  input  logic [SHW-1:0]      leak_shift,
  input  logic                learn_mode,
  input  logic                filter_sel,
  input  logic                wb_done,
  output logic                spike,
  output logic signed [W-1:0] vmem
);

  localparam int XW = W + 2;
  localparam logic signed [W-1:0]  VMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0]  VMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [XW-1:0] XMAX = {2'b00, VMAX};
  localparam logic signed [XW-1:0] XMIN = {2'b11, VMIN};

  function automatic logic signed [W-1:0] clip(input logic signed [XW-1:0] x);
    if (x > XMAX)      return VMAX;
    else if (x < XMIN) return VMIN;
    else               return x[W-1:0];
  endfunction

  logic chk_q, hold_q;
  logic signed [W-1:0]  shifted;
  logic signed [XW-1:0] vmem_x, sum_x, leak_x, diff_x;

  wire gated   = learn_mode && !filter_sel;
  wire open_q  = !chk_q && !hold_q && !gated;
  wire do_leak = open_q && window_done;
  wire do_acc  = open_q && psum_valid && !window_done;
  wire fire    = chk_q && (vmem > threshold);

  assign shifted = vmem >>> leak_shift;
  assign vmem_x  = {{2{vmem[W-1]}}, vmem};
  assign sum_x   = vmem_x + {{2{psum[W-1]}}, psum};
  assign leak_x  = {{2{leak_offset[W-1]}}, leak_offset} + {{2{shifted[W-1]}}, shifted};
  assign diff_x  = vmem_x - leak_x;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vmem   <= '0;
      spike  <= 1'b0;
      chk_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      spike <= fire;
      chk_q <= do_leak;
      if (fire) begin
        vmem   <= '0;
        hold_q <= learn_mode;
      end else if (hold_q && wb_done) begin
        hold_q <= 1'b0;
      end
      if (do_leak)     vmem <= clip(diff_x);
      else if (do_acc) vmem <= clip(sum_x);
    end
  end

  // R5: a spike never lasts beyond one cycle
  assert_spike_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    spike |=> !spike);

  // R4: firing clears the potential together with the spike
  assert_fire_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    spike |-> vmem == '0);

  // R4: a rising spike follows a window end by two edges
  assert_spike_after_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spike) |-> $past(window_done, 2));

  // R6: during the hold the potential stays at zero and no spike occurs
  assert_hold_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !wb_done) |=> (vmem == '0 && !spike));

  // R7: an unselected cell in learning mode keeps its potential
  assert_unselected_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gated && !chk_q && !hold_q) |=> $stable(vmem));

endmodule

// File: tb/lif_neuron_cell_tb.sv
module lif_neuron_cell_tb;

  logic clk = 1'b0;
  logic rst_n, psum_valid, window_done, learn_mode, filter_sel, wb_done;
  logic signed [15:0] psum, threshold, leak_offset;
  logic [3:0] leak_shift;
  logic spike;
  logic signed [15:0] vmem;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  lif_neuron_cell u_dut (
    .clk(clk), .rst_n(rst_n), .psum_valid(psum_valid), .psum(psum),
    .window_done(window_done), .threshold(threshold), .leak_offset(leak_offset),
    .leak_shift(leak_shift), .learn_mode(learn_mode), .filter_sel(filter_sel),
    .wb_done(wb_done), .spike(spike), .vmem(vmem)
  );

  function automatic int sat16(input int x);
    if (x > 32767)  return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  function automatic int leaked(input int v, input int off, input int sh);
    return sat16(v - (off + (v >>> sh)));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    psum_valid = 1'b0; psum = '0; window_done = 1'b0; wb_done = 1'b0;
  endtask

  task automatic do_reset();
    quiet();
    rst_n = 1'b0;
    cyc(); cyc();
    rst_n = 1'b1;
  endtask

  task automatic add(input int p);
    psum_valid = 1'b1; psum = 16'(p);
    cyc();
    quiet();
  endtask

  task automatic t_reset();
    learn_mode = 1'b0; filter_sel = 1'b0;
    threshold = 16'sd1000; leak_offset = '0; leak_shift = 4'd15;
    @(negedge clk);
    do_reset();
    chk("R1 vmem", vmem, 0);
    chk("R1 spike", spike, 0);
  endtask

  task automatic t_accumulate();
    int e = 0;
    do_reset();
    add(100);  e = sat16(e + 100);  chk("R2 add 100", vmem, e);
    add(-30);  e = sat16(e - 30);   chk("R2 add -30", vmem, e);
    add(250);  e = sat16(e + 250);  chk("R2 add 250", vmem, e);
    psum = 16'sd999; psum_valid = 1'b0;
    cyc(); quiet();
    chk("R2 no enable", vmem, e);
  endtask

  task automatic t_leak_nofire();
    int e;
    do_reset();
    threshold = 16'sd10000; leak_offset = 16'sd5; leak_shift = 4'd3;
    add(320);
    window_done = 1'b1; psum_valid = 1'b1; psum = 16'sd999;
    cyc(); quiet();
    e = leaked(320, 5, 3);
    chk("R3 leak, psum dropped", vmem, e);
    window_done = 1'b1; psum_valid = 1'b1; psum = 16'sd500;
    cyc(); quiet();
    chk("R4 check cycle ignores inputs", vmem, e);
    chk("R4 no spike below threshold", spike, 0);
    add(10);
    chk("R4 potential carried", vmem, e + 10);
  endtask

  task automatic t_fire();
    int e;
    do_reset();
    threshold = 16'sd1000; leak_offset = '0; leak_shift = 4'd4;
    add(2000);
    window_done = 1'b1; cyc(); quiet();
    e = leaked(2000, 0, 4);
    chk("R3 leak before fire", vmem, e);
    cyc();
    chk("R4 spike", spike, 1);
    chk("R4 reset to zero", vmem, 0);
    psum_valid = 1'b1; psum = 16'sd40;
    cyc(); quiet();
    chk("R5 spike one cycle", spike, 0);
    chk("R6 no hold outside learning", vmem, 40);
    threshold = 16'(leaked(40, 0, 4));
    window_done = 1'b1; cyc(); quiet();
    cyc();
    chk("R4 equal threshold no spike", spike, 0);
    chk("R4 equal threshold kept", vmem, leaked(40, 0, 4));
  endtask

  task automatic t_saturation();
    do_reset();
    threshold = 16'sd32767;
    add(30000); add(30000);
    chk("R2 positive saturation", vmem, 32767);
    leak_offset = -16'sd100; leak_shift = 4'd15;
    window_done = 1'b1; cyc(); quiet();
    chk("R8 leak saturates high", vmem, 32767);
    cyc();
    chk("R4 no spike at max", spike, 0);
    do_reset();
    threshold = 16'sd32767;
    add(-30000); add(-30000);
    chk("R2 negative saturation", vmem, -32768);
    leak_offset = 16'sd100;
    window_done = 1'b1; cyc(); quiet();
    chk("R8 leak saturates low", vmem, -32768);
    cyc();
  endtask

  task automatic t_learn_hold();
    do_reset();
    learn_mode = 1'b1; filter_sel = 1'b1;
    threshold = 16'sd50; leak_offset = '0; leak_shift = 4'd15;
    add(200);
    window_done = 1'b1; cyc(); quiet();
    cyc();
    chk("R6 fire in learning", spike, 1);
    for (int i = 0; i < 3; i++) begin
      psum_valid = 1'b1; psum = 16'sd77; window_done = (i == 1);
      cyc(); quiet();
      chk("R6 held at zero", vmem, 0);
    end
    chk("R6 no spike in hold", spike, 0);
    wb_done = 1'b1; psum_valid = 1'b1; psum = 16'sd77;
    cyc(); quiet();
    chk("R6 release cycle ignores psum", vmem, 0);
    add(77);
    chk("R6 resumes after release", vmem, 77);
  endtask

  task automatic t_unselected();
    learn_mode = 1'b1; filter_sel = 1'b0;
    add(500);
    chk("R7 unselected ignores psum", vmem, 77);
    leak_offset = 16'sd30;
    window_done = 1'b1; cyc(); quiet();
    chk("R7 unselected ignores window", vmem, 77);
    cyc();
    chk("R7 unselected no spike", spike, 0);
    learn_mode = 1'b0;
    add(23);
    chk("R7 select ignored outside learning", vmem, 100);
  endtask

  initial begin
    rst_n = 1'b0;
    quiet();
    t_reset();
    t_accumulate();
    t_leak_nofire();
    t_fire();
    t_saturation();
    t_learn_hold();
    t_unselected();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule